// File: doc/BRIEF.md
# SECDED Error-Correcting Datapath

This block sits between the local data path of a memory controller and a memory data bus that is 72 bits wide per lane. The local data is split into 64-bit lanes, two by default for a 128-bit local word. On the write path each lane gains eight check bits from an extended Hamming code, and the codeword appears one clock later. On the read path each 72-bit lane codeword is decoded one clock after it arrives. Any single flipped bit is corrected. A pair of flipped bits is reported on an error output that is timed with the read-valid output. Each lane is encoded and decoded on its own.

The block also keeps an error record. It has two saturating counters, one for single-bit events and one for double-bit events. It has a status bit that tells whether the latest erroring read was single-bit only, a register that holds that read's address, and a sticky interrupt. For test, a write can have one or two data bits flipped in any chosen lane after encoding, so that correction and detection can be exercised through real memory contents.

Top module: `ecc_datapath`

## Requirements
- R1: `wr_valid_o` rises exactly one clock after `wr_valid_i`. Lane i of `wr_cw_o` is bits [72*i+71 : 72*i], with the lane's 64 data bits in the low part of that slice and its 8 check bits in the high part. Bit 71 of a lane slice is the overall parity bit.
- R2: `rd_valid_o` follows `rd_valid_i` by exactly one clock. When a codeword from the write path returns unaltered, the original data appears on `rd_data_o` and `rd_err_o` stays low.
- R3: Flipping any one of the 72 bits of a lane codeword still returns the original data for that lane.
- R4: Flipping two bits of a lane codeword asserts `rd_err_o` in the same cycle as `rd_valid_o`. `rd_err_o` is never high while `rd_valid_o` is low.
- R5: Lanes are independent. Errors in one lane leave the data of the other lanes correct.
- R6: `sbe_cnt_o` increases by the number of lanes that had a corrected event in a read beat, and `dbe_cnt_o` increases by the number of lanes that had a double-bit event. Both counts stop at 2^CNT_W-1. The counts are visible one clock after `rd_valid_o`.
- R7: A `cnt_clr_i` pulse zeroes both counters on the next clock. It wins over an increment in the same cycle.
- R8: `irq_o` is set one clock after any erroring read beat and stays high until `irq_ack_i`. When an acknowledge and a new error arrive in the same cycle, `irq_o` stays set.
- R9: After an erroring beat, `last_sbe_o` is 1 if that beat had only single-bit events and 0 if any lane had a double-bit event. Double-bit events take priority. `err_addr_o` holds that beat's `rd_addr_i`. Both update one clock after `rd_valid_o`.
- R10: During a write, `inj_en_i[i]` flips data bit 0 of lane i in the emitted codeword. With `inj_two_i` also high, data bit 1 is flipped as well. Reading such a codeword back gives a corrected read, or an error flag, respectively.
- R11: A flip of only the overall parity bit (lane bit 71) is corrected and counted as a single-bit event.
- R12: After reset, all outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_valid_i | input | 1 | Write beat valid |
| wr_data_i | input | 64*LANES | Local write data |
| inj_en_i | input | LANES | Per-lane error injection enable for this write |
| inj_two_i | input | 1 | Inject two bits instead of one |
| wr_valid_o | output | 1 | Encoded beat valid |
| wr_cw_o | output | 72*LANES | Encoded codewords to memory |
| rd_valid_i | input | 1 | Read beat valid from memory |
| rd_cw_i | input | 72*LANES | Codewords from memory |
| rd_addr_i | input | ADDR_W | Address of the read beat |
| rd_valid_o | output | 1 | Decoded beat valid |
| rd_data_o | output | 64*LANES | Corrected read data |
| rd_err_o | output | 1 | Uncorrectable error in this beat |
| cnt_clr_i | input | 1 | Clear both error counters |
| irq_ack_i | input | 1 | Acknowledge the interrupt |
| sbe_cnt_o | output | CNT_W | Single-bit event count |
| dbe_cnt_o | output | CNT_W | Double-bit event count |
| last_sbe_o | output | 1 | Latest erroring beat was single-bit only |
| err_addr_o | output | ADDR_W | Address of the latest erroring beat |
| irq_o | output | 1 | Sticky error interrupt |

## Verification
The hardest conditions to reach from the ports are counter saturation and collisions in a single cycle. These are an acknowledge arriving together with a new error, a clear arriving together with an increment, and both lanes failing in different ways in one beat. The bench reaches saturation by replaying one codeword with a single flip in both lanes until the count passes its maximum. It reaches the collisions by driving the acknowledge or clear on the exact edge at which the erroring beat reaches the tracker. Codewords for corruption always come from the block's own write path, and the bench flips bits in them at chosen positions. The expected data is therefore simply the data that was written.

// File: rtl/ecc_pkg.sv
package ecc_pkg;
    localparam int DW   = 64;
    localparam int PW   = 7;
    localparam int CW_B = 8;
    localparam int LW   = DW + CW_B;
    localparam int TOPP = LW - 1;

    typedef struct packed {
        logic [DW-1:0] data;
        logic          sbe;
        logic          dbe;
    } dec_res_t;

    // Hamming syndrome contribution of the data bits: XOR of the codeword
    // positions (non powers of two, 3..71) of every set data bit.
    function automatic logic [PW-1:0] data_syn(input logic [DW-1:0] d);
        logic [PW-1:0] s;
        int k;
        s = '0;
        k = 0;
        for (int q = 3; q < LW; q++) begin
            if ((q & (q - 1)) != 0) begin
                if (d[k]) s = s ^ PW'(q);
                k++;
            end
        end
        return s;
    endfunction

    function automatic logic [CW_B-1:0] make_chk(input logic [DW-1:0] d);
        logic [PW-1:0] s;
        s = data_syn(d);
        return {(^d) ^ (^s), s};
    endfunction

    function automatic dec_res_t decode(input logic [DW-1:0] d,
                                        input logic [CW_B-1:0] c);
        dec_res_t r;
        logic [PW-1:0] syn;
        logic par;
        int k;
        syn = data_syn(d) ^ c[PW-1:0];
        par = (^d) ^ (^c);
        r.data = d;
        r.sbe  = 1'b0;
        r.dbe  = 1'b0;
        if (par) begin
            if (int'(syn) > TOPP) begin
                r.dbe = 1'b1;
            end else begin
                r.sbe = 1'b1;
                k = 0;
                for (int q = 3; q < LW; q++) begin
                    if ((q & (q - 1)) != 0) begin
                        if (PW'(q) == syn) r.data[k] = ~d[k];
                        k++;
                    end
                end
            end
        end else if (syn != '0) begin
            r.dbe = 1'b1;
        end
        return r;
    endfunction
endpackage

// File: rtl/ecc_enc_lane.sv
module ecc_enc_lane
    import ecc_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic          valid_i,
    input  logic [DW-1:0] data_i,
    input  logic          inj_i,
    input  logic          inj_two_i,
    output logic [LW-1:0] cw_o
);
    logic [DW-1:0] flip;

    always_comb begin
        flip = '0;
        if (inj_i) begin
            flip[0] = 1'b1;
            flip[1] = inj_two_i;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cw_o <= '0;
        end else if (valid_i) begin
            cw_o <= {make_chk(data_i), data_i ^ flip};
        end
    end
endmodule

// File: rtl/ecc_dec_lane.sv
module ecc_dec_lane
    import ecc_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic          valid_i,
    input  logic [LW-1:0] cw_i,
    output logic [DW-1:0] data_o,
    output logic          sbe_o,
    output logic          dbe_o
);
    dec_res_t res;

    always_comb res = decode(cw_i[DW-1:0], cw_i[LW-1:DW]);

    always_ff @(posedge clk) begin
        if (rst) begin
            data_o <= '0;
            sbe_o  <= 1'b0;
            dbe_o  <= 1'b0;
        end else begin
            sbe_o <= valid_i & res.sbe;
            dbe_o <= valid_i & res.dbe;
            if (valid_i) data_o <= res.data;
        end
    end

    assert_excl_flags_R4: assert property (@(posedge clk) disable iff (rst)
        !(sbe_o && dbe_o));
endmodule

// File: rtl/ecc_err_track.sv
module ecc_err_track #(
    parameter int LANES  = 2,
    parameter int ADDR_W = 32,
    parameter int CNT_W  = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              valid_i,
    input  logic [LANES-1:0]  sbe_i,
    input  logic [LANES-1:0]  dbe_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic              clr_i,
    input  logic              ack_i,
    output logic [CNT_W-1:0]  sbe_cnt_o,
    output logic [CNT_W-1:0]  dbe_cnt_o,
    output logic              last_sbe_o,
    output logic [ADDR_W-1:0] addr_o,
    output logic              irq_o
);
    localparam int SUM_W = CNT_W + 1;
    localparam logic [CNT_W-1:0] MAXC = '1;

    logic [SUM_W-1:0] sbe_sum, dbe_sum;
    logic             any_err;

    always_comb begin
        sbe_sum = {1'b0, sbe_cnt_o} + SUM_W'($countones(sbe_i));
        dbe_sum = {1'b0, dbe_cnt_o} + SUM_W'($countones(dbe_i));
        any_err = valid_i && ((|sbe_i) || (|dbe_i));
    end

    always_ff @(posedge clk) begin
        if (rst || clr_i) begin
            sbe_cnt_o <= '0;
            dbe_cnt_o <= '0;
        end else if (valid_i) begin
            sbe_cnt_o <= sbe_sum[CNT_W] ? MAXC : sbe_sum[CNT_W-1:0];
            dbe_cnt_o <= dbe_sum[CNT_W] ? MAXC : dbe_sum[CNT_W-1:0];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            last_sbe_o <= 1'b0;
            addr_o     <= '0;
            irq_o      <= 1'b0;
        end else begin
            if (any_err) begin
                last_sbe_o <= ~(|dbe_i);
                addr_o     <= addr_i;
            end
            if (any_err)     irq_o <= 1'b1;
            else if (ack_i)  irq_o <= 1'b0;
        end
    end

    assert_irq_sticky_R8: assert property (@(posedge clk) disable iff (rst)
        (irq_o && !ack_i) |=> irq_o);
    assert_cnt_clear_R7: assert property (@(posedge clk) disable iff (rst)
        clr_i |=> (sbe_cnt_o == '0 && dbe_cnt_o == '0));
    assert_cnt_mono_R6: assert property (@(posedge clk) disable iff (rst)
        !clr_i |=> (sbe_cnt_o >= $past(sbe_cnt_o) && dbe_cnt_o >= $past(dbe_cnt_o)));
    assert_dbe_priority_R9: assert property (@(posedge clk) disable iff (rst)
        (valid_i && (|dbe_i)) |=> !last_sbe_o);
endmodule

// File: rtl/ecc_datapath.sv
module ecc_datapath
    import ecc_pkg::*;
#(
    parameter int LANES  = 2,
    parameter int ADDR_W = 32,
    parameter int CNT_W  = 8
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  wr_valid_i,
    input  logic [DW*LANES-1:0]   wr_data_i,
    input  logic [LANES-1:0]      inj_en_i,
    input  logic                  inj_two_i,
    output logic                  wr_valid_o,
    output logic [LW*LANES-1:0]   wr_cw_o,
    input  logic                  rd_valid_i,
    input  logic [LW*LANES-1:0]   rd_cw_i,
    input  logic [ADDR_W-1:0]     rd_addr_i,
    output logic                  rd_valid_o,
    output logic [DW*LANES-1:0]   rd_data_o,
    output logic                  rd_err_o,
    input  logic                  cnt_clr_i,
    input  logic                  irq_ack_i,
    output logic [CNT_W-1:0]      sbe_cnt_o,
    output logic [CNT_W-1:0]      dbe_cnt_o,
    output logic                  last_sbe_o,
    output logic [ADDR_W-1:0]     err_addr_o,
    output logic                  irq_o
);
    logic [LANES-1:0]  sbe_v, dbe_v;
    logic [ADDR_W-1:0] addr_q;

    for (genvar i = 0; i < LANES; i++) begin : g_lane
        ecc_enc_lane u_enc (
            .clk       (clk),
            .rst       (rst),
            .valid_i   (wr_valid_i),
            .data_i    (wr_data_i[DW*i +: DW]),
            .inj_i     (inj_en_i[i]),
            .inj_two_i (inj_two_i),
            .cw_o      (wr_cw_o[LW*i +: LW])
        );
        ecc_dec_lane u_dec (
            .clk     (clk),
            .rst     (rst),
            .valid_i (rd_valid_i),
            .cw_i    (rd_cw_i[LW*i +: LW]),
            .data_o  (rd_data_o[DW*i +: DW]),
            .sbe_o   (sbe_v[i]),
            .dbe_o   (dbe_v[i])
        );
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_valid_o <= 1'b0;
            rd_valid_o <= 1'b0;
            addr_q     <= '0;
        end else begin
            wr_valid_o <= wr_valid_i;
            rd_valid_o <= rd_valid_i;
            if (rd_valid_i) addr_q <= rd_addr_i;
        end
    end

    assign rd_err_o = |dbe_v;

    ecc_err_track #(.LANES(LANES), .ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_track (
        .clk        (clk),
        .rst        (rst),
        .valid_i    (rd_valid_o),
        .sbe_i      (sbe_v),
        .dbe_i      (dbe_v),
        .addr_i     (addr_q),
        .clr_i      (cnt_clr_i),
        .ack_i      (irq_ack_i),
        .sbe_cnt_o  (sbe_cnt_o),
        .dbe_cnt_o  (dbe_cnt_o),
        .last_sbe_o (last_sbe_o),
        .addr_o     (err_addr_o),
        .irq_o      (irq_o)
    );

    assert_wr_latency_R1: assert property (@(posedge clk) disable iff (rst)
        wr_valid_i |=> wr_valid_o);
    assert_rd_latency_R2: assert property (@(posedge clk) disable iff (rst)
        rd_valid_i |=> rd_valid_o);
    assert_err_with_valid_R4: assert property (@(posedge clk) disable iff (rst)
        rd_err_o |-> rd_valid_o);
    assert_irq_on_error_R8: assert property (@(posedge clk) disable iff (rst)
        (rd_valid_o && (|sbe_v || |dbe_v)) |=> irq_o);
endmodule

// File: tb/tb_ecc_datapath.sv
module tb_ecc_datapath;
    localparam int LANES = 2;
    localparam int AW = 32;
    localparam int CW = 8;

    logic clk = 0;
    logic rst = 1;
    logic wr_valid_i = 0, inj_two_i = 0, rd_valid_i = 0, cnt_clr_i = 0, irq_ack_i = 0;
    logic [127:0] wr_data_i = '0;
    logic [1:0] inj_en_i = '0;
    logic [143:0] rd_cw_i = '0;
    logic [AW-1:0] rd_addr_i = '0;
    logic wr_valid_o, rd_valid_o, rd_err_o, last_sbe_o, irq_o;
    logic [143:0] wr_cw_o;
    logic [127:0] rd_data_o;
    logic [CW-1:0] sbe_cnt_o, dbe_cnt_o;
    logic [AW-1:0] err_addr_o;

    int checks = 0;
    int fails = 0;

    always #10 clk = ~clk;

    ecc_datapath #(.LANES(LANES), .ADDR_W(AW), .CNT_W(CW)) dut (.*);

    task automatic chk(input bit ok, input string req, input logic [127:0] act,
                       input logic [127:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic encode(input logic [127:0] d, input logic [1:0] inj, input bit two,
                          output logic [143:0] cw, output bit v);
        @(negedge clk);
        wr_valid_i = 1; wr_data_i = d; inj_en_i = inj; inj_two_i = two;
        @(posedge clk);
        @(negedge clk);
        v = wr_valid_o; cw = wr_cw_o;
        wr_valid_i = 0; inj_en_i = 0; inj_two_i = 0;
    endtask

    task automatic rd(input logic [143:0] cw, input logic [AW-1:0] a, input bit ack,
                      input bit clr, output logic [127:0] d, output bit v, output bit e);
        @(negedge clk);
        rd_valid_i = 1; rd_cw_i = cw; rd_addr_i = a;
        @(posedge clk);
        @(negedge clk);
        rd_valid_i = 0; irq_ack_i = ack; cnt_clr_i = clr;
        v = rd_valid_o; d = rd_data_o; e = rd_err_o;
        @(posedge clk);
        @(negedge clk);
        irq_ack_i = 0; cnt_clr_i = 0;
    endtask

    task automatic clear_all();
        @(negedge clk); cnt_clr_i = 1; irq_ack_i = 1;
        @(negedge clk); cnt_clr_i = 0; irq_ack_i = 0;
    endtask

    task automatic t_reset();
        chk(!wr_valid_o && !rd_valid_o && !rd_err_o && !irq_o && !last_sbe_o
            && sbe_cnt_o == 0 && dbe_cnt_o == 0 && err_addr_o == 0 && wr_cw_o == 0
            && rd_data_o == 0, "R12 reset", {sbe_cnt_o, dbe_cnt_o, err_addr_o}, 0);
    endtask

    task automatic t_clean();
        logic [127:0] pats [3];
        logic [143:0] cw; logic [127:0] d; bit v, e;
        pats[0] = '0; pats[1] = '1; pats[2] = 128'h0123456789abcdef_fedcba9876543210;
        foreach (pats[i]) begin
            encode(pats[i], 2'b00, 0, cw, v);
            chk(v && cw[63:0] == pats[i][63:0] && cw[135:72] == pats[i][127:64],
                "R1 encode", cw[127:0], pats[i]);
            rd(cw, 32'h10 + i, 0, 0, d, v, e);
            chk(v && !e && d == pats[i], "R2 clean read", d, pats[i]);
        end
        chk(sbe_cnt_o == 0 && dbe_cnt_o == 0 && !irq_o, "R2 no events", sbe_cnt_o, 0);
    endtask

    task automatic t_single_all();
        logic [127:0] p = 128'hdeadbeef_00c0ffee_5a5a5a5a_a5a5a5a5;
        logic [143:0] cw, c2; logic [127:0] d; bit v, e;
        encode(p, 2'b00, 0, cw, v);
        for (int b = 0; b < 72; b++) begin
            c2 = cw; c2[b] = ~c2[b];
            rd(c2, 32'h100 + b, 0, 0, d, v, e);
            chk(v && !e && d == p, "R3 single flip lane0", d, p);
        end
        for (int b = 72; b < 144; b += 7) begin
            c2 = cw; c2[b] = ~c2[b];
            rd(c2, 32'h200 + b, 0, 0, d, v, e);
            chk(v && !e && d == p, "R3 single flip lane1", d, p);
        end
        clear_all();
    endtask

    task automatic t_parity_bit();
        logic [127:0] p = 128'h1111_2222_3333_4444_5555_6666_7777_8888;
        logic [143:0] cw; logic [127:0] d; bit v, e;
        encode(p, 2'b00, 0, cw, v);
        cw[71] = ~cw[71];
        rd(cw, 32'h71, 0, 0, d, v, e);
        chk(!e && d == p, "R11 parity bit data", d, p);
        chk(sbe_cnt_o == 1 && dbe_cnt_o == 0 && last_sbe_o, "R11 parity bit counted",
            sbe_cnt_o, 1);
        clear_all();
    endtask

    task automatic t_double();
        logic [127:0] p = 128'hcafef00d_12345678_87654321_0badf00d;
        logic [143:0] cw, c2; logic [127:0] d; bit v, e;
        int pairs [5][2] = '{'{0,1}, '{0,71}, '{64,65}, '{3,40}, '{70,71}};
        encode(p, 2'b00, 0, cw, v);
        foreach (pairs[i]) begin
            c2 = cw; c2[pairs[i][0]] = ~c2[pairs[i][0]]; c2[pairs[i][1]] = ~c2[pairs[i][1]];
            rd(c2, 32'h300 + i, 0, 0, d, v, e);
            chk(v && e, "R4 double flag", {126'b0, v, e}, 3);
            chk(d[127:64] == p[127:64], "R5 other lane intact", d[127:64], p[127:64]);
        end
        chk(dbe_cnt_o == 5 && sbe_cnt_o == 0, "R6 dbe count", dbe_cnt_o, 5);
        clear_all();
    endtask

    task automatic t_priority();
        logic [127:0] p = 128'h0f0f0f0f_f0f0f0f0_33333333_cccccccc;
        logic [143:0] cw, c2; logic [127:0] d; bit v, e;
        encode(p, 2'b00, 0, cw, v);
        c2 = cw; c2[5] = ~c2[5]; c2[80] = ~c2[80]; c2[81] = ~c2[81];
        rd(c2, 32'hABCD0001, 0, 0, d, v, e);
        chk(e && d[63:0] == p[63:0], "R5 lane0 corrected beside lane1 dbe", d[63:0], p[63:0]);
        chk(!last_sbe_o && err_addr_o == 32'hABCD0001, "R9 dbe priority and addr",
            {last_sbe_o, err_addr_o}, {1'b0, 32'hABCD0001});
        chk(sbe_cnt_o == 1 && dbe_cnt_o == 1, "R6 per-lane counts", {sbe_cnt_o, dbe_cnt_o}, 16'h0101);
        c2 = cw; c2[9] = ~c2[9];
        rd(c2, 32'h00005555, 0, 0, d, v, e);
        chk(last_sbe_o && err_addr_o == 32'h5555, "R9 sbe status", {last_sbe_o, err_addr_o},
            {1'b1, 32'h5555});
        rd(cw, 32'h00009999, 0, 0, d, v, e);
        chk(err_addr_o == 32'h5555, "R9 addr held on clean read", err_addr_o, 32'h5555);
        clear_all();
    endtask

    task automatic t_irq();
        logic [127:0] p = 128'h42;
        logic [143:0] cw, c2; logic [127:0] d; bit v, e;
        encode(p, 2'b00, 0, cw, v);
        c2 = cw; c2[100] = ~c2[100];
        rd(c2, 32'h1, 0, 0, d, v, e);
        chk(irq_o, "R8 irq set", irq_o, 1);
        rd(cw, 32'h2, 0, 0, d, v, e);
        chk(irq_o, "R8 irq sticky", irq_o, 1);
        rd(c2, 32'h3, 1, 0, d, v, e);
        chk(irq_o, "R8 ack with new error keeps irq", irq_o, 1);
        @(negedge clk); irq_ack_i = 1; @(negedge clk); irq_ack_i = 0;
        chk(!irq_o, "R8 ack clears", irq_o, 0);
        clear_all();
    endtask

    task automatic t_inject();
        logic [127:0] p = 128'h7777_0000_ffff_1234_4321_aaaa_5555_9876;
        logic [143:0] cw; logic [127:0] d; bit v, e;
        encode(p, 2'b10, 0, cw, v);
        chk(cw[72] != p[64] && cw[73] == p[65] && cw[0] == p[0], "R10 single inject bit",
            {cw[73:72], cw[0]}, {p[65], ~p[64], p[0]});
        rd(cw, 32'h60, 0, 0, d, v, e);
        chk(!e && d == p && sbe_cnt_o == 1, "R10 single inject corrected", d, p);
        encode(p, 2'b01, 1, cw, v);
        chk(cw[1:0] == ~p[1:0] && cw[73:72] == p[65:64], "R10 double inject bits",
            {cw[73:72], cw[1:0]}, {p[65:64], ~p[1:0]});
        rd(cw, 32'h61, 0, 0, d, v, e);
        chk(e && d[127:64] == p[127:64] && dbe_cnt_o == 1, "R10 double inject detected",
            d, p);
        clear_all();
    endtask

    task automatic t_saturate_clear();
        logic [127:0] p = 128'h99;
        logic [143:0] cw, c2; logic [127:0] d; bit v, e;
        encode(p, 2'b11, 0, cw, v);
        for (int i = 0; i < 130; i++) rd(cw, 32'h7, 0, 0, d, v, e);
        chk(sbe_cnt_o == 8'hFF, "R6 sbe saturates", sbe_cnt_o, 8'hFF);
        rd(cw, 32'h8, 0, 0, d, v, e);
        chk(sbe_cnt_o == 8'hFF, "R6 saturated hold", sbe_cnt_o, 8'hFF);
        c2 = cw; c2[2] = ~c2[2];
        rd(c2, 32'h9, 0, 1, d, v, e);
        chk(sbe_cnt_o == 0 && dbe_cnt_o == 0, "R7 clear wins over increment",
            {sbe_cnt_o, dbe_cnt_o}, 0);
        rd(cw, 32'hA, 0, 0, d, v, e);
        chk(sbe_cnt_o == 2, "R6 count after clear", sbe_cnt_o, 2);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk); rst = 0;
        @(negedge clk);
        t_reset();
        t_clean();
        t_single_all();
        t_parity_bit();
        t_double();
        t_priority();
        t_irq();
        t_inject();
        t_saturate_clear();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule